// File: doc/BRIEF.md
# Versatile port and timer adapter

This block is a byte-wide, memory-mapped peripheral. A host reaches sixteen registers through a 4-bit index. Each access lasts one clock cycle and is marked by a select strobe and a write flag. The register set covers:

- two 8-bit ports, each with its own direction register;
- two 16-bit down-counters with reload latches;
- a shift-register data byte;
- auxiliary and peripheral control bytes;
- an interrupt flag/enable pair that drives one level-sensitive interrupt line.

The timers advance only on cycles where the tick input is high. The system clock can therefore be divided by any external prescaler.

An attached controller uses the block as its host-facing port. It watches a one-cycle strobe that marks every port-B write. It also raises the shift-register interrupt through a dedicated set input when a byte transfer completes.

Read data is combinational from the current register state. Read side effects, such as flag clears, are applied at the clock edge that ends the read access.

Top module: `vport_adapter`

## Requirements
- R1: A write to port B (index 0) or port A (index 1, alias index 15) changes only the output bits whose direction bit is 1. Direction registers sit at index 2 (B) and 3 (A). A port read returns the output register on bits whose direction bit is 1 and the input pins on all other bits.
- R2: `pb_wr_stb` is high for exactly one cycle, the cycle right after each port-B write access. It is low at all other times.
- R3: At index 14, a written byte with bit 7 = 1 sets the enable bits marked 1 in bits 6:0. With bit 7 = 0 it clears the enable bits marked 1. Reading index 14 returns bit 7 as 1 and the enables in bits 6:0.
- R4: The flag register is at index 13. Bit 6 is timer 1, bit 5 is timer 2 and bit 2 is the shift register. Reading it returns bit 7 = 1 exactly when some flag is both set and enabled. Writing it clears every flag written as 1 and leaves the others. `irq` is high exactly when a set flag is also enabled.
- R5: Index 5 writes the timer-1 latch high byte, clears the timer-1 flag and loads the counter from the full latch. Indices 4 and 6 write only the latch low byte. Index 7 writes the latch high byte and clears the timer-1 flag without touching the counter. Latch bytes read back at indices 6 and 7.
- R6: Timer 1 decrements once per tick from its loaded value down to 0xFFFF. The tick after that reloads it from the latch, so a free-running period is latch+2 ticks. The flag is raised on the tick that steps the counter from 0 to 0xFFFF. Counter bytes read at indices 4 (low) and 5 (high).
- R7: With auxiliary-control (index 11) bits 7:6 = 01, timer 1 raises its flag in every period. With any other value it raises the flag only once after each index-5 load.
- R8: Index 8 writes the timer-2 latch low byte. Index 9 loads the counter with {written byte, latch low}, clears the timer-2 flag and arms the timer. Timer 2 decrements once per tick without ever reloading. It raises its flag only on the first step from 0 to 0xFFFF after a load. Counter bytes read at indices 8 and 9.
- R9: Reading index 4 clears the timer-1 flag and reading index 8 clears the timer-2 flag. Reading the counter high bytes (5, 9) clears nothing.
- R10: `sr_set` high for a cycle raises the shift-register flag. Index 10 stores a data byte. Reading index 10 returns that byte and clears the shift-register flag.
- R11: After reset the following hold: both latches and both counters are 0xFFFF; all flags, enables, ports, direction, shift, auxiliary and peripheral bytes are 0; `irq` and `pb_wr_stb` are low.
- R12: The auxiliary (index 11) and peripheral (index 12) control bytes read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer count enable, one pulse per timer tick |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write access, 0 = read access |
| idx | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| pa_in | input | 8 | Port A input pins |
| pb_in | input | 8 | Port B input pins |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction, 1 = output |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction, 1 = output |
| sr_set | input | 1 | Raises the shift-register flag |
| pb_wr_stb | output | 1 | One-cycle pulse after each port-B write |
| irq | output | 1 | Level interrupt request |

## Verification
The register walk uses port data patterns whose written values and pin values differ in every nibble. This shows whether direction masking or pin mixing is wrong, and separates set-style from clear-style enable writes.

Timer tests use small latch values so that whole periods fit in a few ticks:
- One case counts exactly latch+2 ticks between flags, which catches off-by-one reload.
- Other cases compare continuous mode with one-shot mode.
- Others compare timer 2's no-reload countdown with timer 1's reload.

Side-effect tests clear flags through each path in turn: low-byte read, high-byte read, latch write, flag write and shift read. Each path is checked to act only on its own flag.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int IDX_W  = 4;
  localparam int FLAG_W = DATA_W - 1;

  localparam int FB_SR = 2;
  localparam int FB_T2 = 5;
  localparam int FB_T1 = 6;
  localparam logic [FLAG_W-1:0] FLAG_MASK =
    FLAG_W'((1 << FB_SR) | (1 << FB_T2) | (1 << FB_T1));

  typedef enum logic [IDX_W-1:0] {
    RG_PB      = 4'h0,
    RG_PA      = 4'h1,
    RG_DIRB    = 4'h2,
    RG_DIRA    = 4'h3,
    RG_T1C_LO  = 4'h4,
    RG_T1C_HI  = 4'h5,
    RG_T1L_LO  = 4'h6,
    RG_T1L_HI  = 4'h7,
    RG_T2C_LO  = 4'h8,
    RG_T2C_HI  = 4'h9,
    RG_SHIFT   = 4'hA,
    RG_AUX     = 4'hB,
    RG_PER     = 4'hC,
    RG_FLAG    = 4'hD,
    RG_ENA     = 4'hE,
    RG_PA_ALT  = 4'hF
  } reg_idx_e;
endpackage

// File: rtl/vpa_timer1.sv
module vpa_timer1
  import vpa_pkg::*;
#(
  parameter int BW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            lat_lo_wr,
  input  logic            lat_hi_wr,
  input  logic            cnt_hi_wr,
  input  logic            cont_mode,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] cnt,
  output logic [2*BW-1:0] latch,
  output logic            fire
);
  localparam int W = 2 * BW;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_n, latch_n;
  logic         armed, armed_n;

  always_comb begin
    cnt_n   = cnt;
    latch_n = latch;
    armed_n = armed;
    fire    = tick_en && !cnt_hi_wr && (cnt == '0) && (armed || cont_mode);
    if (lat_lo_wr) latch_n[BW-1:0] = wdata;
    if (lat_hi_wr || cnt_hi_wr) latch_n[W-1:BW] = wdata;
    if (cnt_hi_wr) begin
      cnt_n   = {wdata, latch[BW-1:0]};
      armed_n = 1'b1;
    end else if (tick_en) begin
      cnt_n = (cnt == ALL1) ? latch : cnt - W'(1);
      if (fire && !cont_mode) armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= ALL1;
      latch <= ALL1;
      armed <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      latch <= latch_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/vpa_timer2.sv
module vpa_timer2
  import vpa_pkg::*;
#(
  parameter int BW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            lat_lo_wr,
  input  logic            cnt_hi_wr,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] cnt,
  output logic            fire
);
  localparam int W = 2 * BW;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_n, latch, latch_n;
  logic         armed, armed_n;

  always_comb begin
    cnt_n   = cnt;
    latch_n = latch;
    armed_n = armed;
    fire    = tick_en && !cnt_hi_wr && (cnt == '0) && armed;
    if (lat_lo_wr) latch_n[BW-1:0] = wdata;
    if (cnt_hi_wr) begin
      latch_n[W-1:BW] = wdata;
      cnt_n           = {wdata, latch[BW-1:0]};
      armed_n         = 1'b1;
    end else if (tick_en) begin
      cnt_n = cnt - W'(1);
      if (fire) armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= ALL1;
      latch <= ALL1;
      armed <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      latch <= latch_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/vpa_irq_ctl.sv
module vpa_irq_ctl
  import vpa_pkg::*;
#(
  parameter int BW = DATA_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_v,
  input  logic [FW-1:0] clr_v,
  input  logic          ena_wr,
  input  logic [BW-1:0] wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] enables,
  output logic          irq
);
  logic [FW-1:0] flags_n, enables_n;

  always_comb begin
    // a same-cycle event wins over a clearing access
    flags_n   = ((flags & ~clr_v) | set_v) & FLAG_MASK;
    enables_n = enables;
    if (ena_wr) begin
      if (wdata[BW-1]) enables_n = enables | wdata[FW-1:0];
      else             enables_n = enables & ~wdata[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags   <= flags_n;
      enables <= enables_n;
    end
  end

  assign irq = |(flags & enables);
endmodule

// File: rtl/vport_adapter.sv
module vport_adapter
  import vpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cs,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_dir,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_dir,
  input  logic              sr_set,
  output logic              pb_wr_stb,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic     wr_acc, rd_acc;
  reg_idx_e sel;
  assign wr_acc = cs && we;
  assign rd_acc = cs && !we;
  assign sel    = reg_idx_e'(idx);

  logic [DATA_W-1:0] pa_n, pb_n, pa_dir_n, pb_dir_n;
  logic [DATA_W-1:0] sr_q, sr_n, acr_q, acr_n, pcr_q, pcr_n;
  logic              stb_n;

  always_comb begin
    pa_n     = pa_out;
    pb_n     = pb_out;
    pa_dir_n = pa_dir;
    pb_dir_n = pb_dir;
    sr_n     = sr_q;
    acr_n    = acr_q;
    pcr_n    = pcr_q;
    stb_n    = wr_acc && (sel == RG_PB);
    if (wr_acc) begin
      case (sel)
        RG_PB:            pb_n     = (pb_out & ~pb_dir) | (wdata & pb_dir);
        RG_PA, RG_PA_ALT: pa_n     = (pa_out & ~pa_dir) | (wdata & pa_dir);
        RG_DIRB:          pb_dir_n = wdata;
        RG_DIRA:          pa_dir_n = wdata;
        RG_SHIFT:         sr_n     = wdata;
        RG_AUX:           acr_n    = wdata;
        RG_PER:           pcr_n    = wdata;
        default:          ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pa_out    <= '0;
      pb_out    <= '0;
      pa_dir    <= '0;
      pb_dir    <= '0;
      sr_q      <= '0;
      acr_q     <= '0;
      pcr_q     <= '0;
      pb_wr_stb <= 1'b0;
    end else begin
      pa_out    <= pa_n;
      pb_out    <= pb_n;
      pa_dir    <= pa_dir_n;
      pb_dir    <= pb_dir_n;
      sr_q      <= sr_n;
      acr_q     <= acr_n;
      pcr_q     <= pcr_n;
      pb_wr_stb <= stb_n;
    end
  end

  // timers
  logic [CNT_W-1:0] t1_cnt, t1_latch, t2_cnt;
  logic             t1_fire, t2_fire, t1_cont;
  assign t1_cont = (acr_q[DATA_W-1:DATA_W-2] == 2'b01);

  vpa_timer1 #(.BW(DATA_W)) u_t1 (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_en   (tick_en),
    .lat_lo_wr (wr_acc && (sel == RG_T1C_LO || sel == RG_T1L_LO)),
    .lat_hi_wr (wr_acc && (sel == RG_T1L_HI)),
    .cnt_hi_wr (wr_acc && (sel == RG_T1C_HI)),
    .cont_mode (t1_cont),
    .wdata     (wdata),
    .cnt       (t1_cnt),
    .latch     (t1_latch),
    .fire      (t1_fire)
  );

  vpa_timer2 #(.BW(DATA_W)) u_t2 (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_en   (tick_en),
    .lat_lo_wr (wr_acc && (sel == RG_T2C_LO)),
    .cnt_hi_wr (wr_acc && (sel == RG_T2C_HI)),
    .wdata     (wdata),
    .cnt       (t2_cnt),
    .fire      (t2_fire)
  );

  // interrupt flags
  logic [FLAG_W-1:0] set_v, clr_v, flags, enables;
  always_comb begin
    set_v        = '0;
    set_v[FB_T1] = t1_fire;
    set_v[FB_T2] = t2_fire;
    set_v[FB_SR] = sr_set;
    clr_v        = '0;
    clr_v[FB_T1] = (wr_acc && (sel == RG_T1C_HI || sel == RG_T1L_HI)) ||
                   (rd_acc && (sel == RG_T1C_LO));
    clr_v[FB_T2] = (wr_acc && (sel == RG_T2C_HI)) ||
                   (rd_acc && (sel == RG_T2C_LO));
    clr_v[FB_SR] = rd_acc && (sel == RG_SHIFT);
    if (wr_acc && (sel == RG_FLAG)) clr_v = clr_v | wdata[FLAG_W-1:0];
  end

  vpa_irq_ctl #(.BW(DATA_W), .FW(FLAG_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_v   (set_v),
    .clr_v   (clr_v),
    .ena_wr  (wr_acc && (sel == RG_ENA)),
    .wdata   (wdata),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    case (sel)
      RG_PB:            rdata = (pb_out & pb_dir) | (pb_in & ~pb_dir);
      RG_PA, RG_PA_ALT: rdata = (pa_out & pa_dir) | (pa_in & ~pa_dir);
      RG_DIRB:          rdata = pb_dir;
      RG_DIRA:          rdata = pa_dir;
      RG_T1C_LO:        rdata = t1_cnt[DATA_W-1:0];
      RG_T1C_HI:        rdata = t1_cnt[CNT_W-1:DATA_W];
      RG_T1L_LO:        rdata = t1_latch[DATA_W-1:0];
      RG_T1L_HI:        rdata = t1_latch[CNT_W-1:DATA_W];
      RG_T2C_LO:        rdata = t2_cnt[DATA_W-1:0];
      RG_T2C_HI:        rdata = t2_cnt[CNT_W-1:DATA_W];
      RG_SHIFT:         rdata = sr_q;
      RG_AUX:           rdata = acr_q;
      RG_PER:           rdata = pcr_q;
      RG_FLAG:          rdata = {|(flags & enables), flags};
      RG_ENA:           rdata = {1'b1, enables};
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/vpa_checker.sv
module vpa_checker
  import vpa_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic              tick_en,
  input logic              cs,
  input logic              we,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              sr_set,
  input logic              pb_wr_stb,
  input logic [CNT_W-1:0]  t1_cnt,
  input logic [CNT_W-1:0]  t1_latch,
  input logic [CNT_W-1:0]  t2_cnt,
  input logic              t1_fire,
  input logic [FLAG_W-1:0] flags
);
  a_r2_stb_follows_pb_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && we && idx == 4'h0) |=> pb_wr_stb);

  a_r2_stb_only_after_pb_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    pb_wr_stb |-> $past(cs && we && idx == 4'h0));

  a_r3_ena_read_top_bit: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && !we && idx == 4'hE) |-> rdata[DATA_W-1]);

  a_r4_flag_write_clears_t1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && we && idx == 4'hD && wdata[FB_T1] && !t1_fire) |=> !flags[FB_T1]);

  a_r5_t1_hi_write_loads: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && we && idx == 4'h5) |=> (t1_cnt == {$past(wdata), t1_latch[DATA_W-1:0]}));

  a_r6_t1_reload_from_latch: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick_en && !(cs && we) && t1_cnt == {CNT_W{1'b1}}) |=> (t1_cnt == $past(t1_latch)));

  a_r8_t2_steps_down: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick_en && !(cs && we && idx == 4'h9)) |=> (t2_cnt == $past(t2_cnt) - CNT_W'(1)));

  a_r10_sr_set_raises_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    sr_set |=> flags[FB_SR]);
endmodule

bind vport_adapter vpa_checker u_vpa_checker (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .tick_en    (tick_en),
  .cs         (cs),
  .we         (we),
  .idx        (idx),
  .wdata      (wdata),
  .rdata      (rdata),
  .sr_set     (sr_set),
  .pb_wr_stb  (pb_wr_stb),
  .t1_cnt     (t1_cnt),
  .t1_latch   (t1_latch),
  .t2_cnt     (t2_cnt),
  .t1_fire    (t1_fire),
  .flags      (flags)
);

// File: tb/vport_adapter_bench.sv
`timescale 1ns/1ps
module vport_adapter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [3:0] idx = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h0A;
  logic [7:0] pb_in = 8'h30;
  logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
  logic       sr_set = 1'b0;
  logic       pb_wr_stb, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vport_adapter u_vport_adapter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cs(cs), .we(we), .idx(idx),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pb_in(pb_in),
    .pa_out(pa_out), .pa_dir(pa_dir), .pb_out(pb_out), .pb_dir(pb_dir),
    .sr_set(sr_set), .pb_wr_stb(pb_wr_stb), .irq(irq)
  );

  // vector: {read, index, data (write data or expected read data)}
  localparam int NV = 33;
  localparam logic [12:0] VECS [0:NV-1] = '{
    {1'b0, 4'h2, 8'h0F}, {1'b0, 4'h0, 8'hA5}, {1'b1, 4'h0, 8'h35},
    {1'b1, 4'h2, 8'h0F}, {1'b0, 4'h0, 8'hFF}, {1'b1, 4'h0, 8'h3F},
    {1'b0, 4'h3, 8'hF0}, {1'b0, 4'h1, 8'h3C}, {1'b1, 4'h1, 8'h3A},
    {1'b1, 4'hF, 8'h3A}, {1'b0, 4'hF, 8'hC3}, {1'b1, 4'h1, 8'hCA},
    {1'b0, 4'hE, 8'hE0}, {1'b1, 4'hE, 8'hE0}, {1'b0, 4'hE, 8'h20},
    {1'b1, 4'hE, 8'hC0}, {1'b0, 4'hE, 8'h84}, {1'b1, 4'hE, 8'hC4},
    {1'b0, 4'hB, 8'h40}, {1'b1, 4'hB, 8'h40}, {1'b0, 4'hC, 8'h5A},
    {1'b1, 4'hC, 8'h5A}, {1'b0, 4'hA, 8'h96}, {1'b1, 4'hA, 8'h96},
    {1'b0, 4'h6, 8'h34}, {1'b0, 4'h7, 8'h12}, {1'b1, 4'h6, 8'h34},
    {1'b1, 4'h7, 8'h12}, {1'b1, 4'h4, 8'hFF}, {1'b1, 4'h5, 8'hFF},
    {1'b0, 4'h8, 8'h78}, {1'b1, 4'h8, 8'hFF}, {1'b1, 4'hD, 8'h00}
  };

  function automatic string tag_of(logic [3:0] i);
    case (i)
      4'h0, 4'h1, 4'h2, 4'h3, 4'hF: return "R1";
      4'h4, 4'h5, 4'h6, 4'h7:       return "R5";
      4'h8, 4'h9:                   return "R8";
      4'hA:                         return "R10";
      4'hB, 4'hC:                   return "R12";
      4'hD:                         return "R4";
      default:                      return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] i, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [3:0] i, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; idx = i;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] i, logic [7:0] exp);
    logic [7:0] v;
    rd(i, v);
    check(tag, v, exp);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic pulse_sr;
    @(negedge clk); sr_set = 1'b1;
    @(negedge clk); sr_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11 irq", {7'b0, irq}, 8'h00);
    check("R11 pb_wr_stb", {7'b0, pb_wr_stb}, 8'h00);
    check("R11 pb_out", pb_out, 8'h00);
    rd_chk("R11 t1 cnt lo", 4'h4, 8'hFF);
    rd_chk("R11 t1 cnt hi", 4'h5, 8'hFF);
    rd_chk("R11 t1 latch lo", 4'h6, 8'hFF);
    rd_chk("R11 t1 latch hi", 4'h7, 8'hFF);
    rd_chk("R11 t2 cnt hi", 4'h9, 8'hFF);
    rd_chk("R11 enables", 4'hE, 8'h80);
    rd_chk("R11 flags", 4'hD, 8'h00);
    rd_chk("R11 dirb", 4'h2, 8'h00);

    // register walk
    for (int v = 0; v < NV; v++) begin
      if (VECS[v][12]) rd_chk(tag_of(VECS[v][11:8]), VECS[v][11:8], VECS[v][7:0]);
      else             wr(VECS[v][11:8], VECS[v][7:0]);
    end

    // R6/R7: timer 1 continuous, period latch+2
    wr(4'hE, 8'h7F);
    wr(4'hE, 8'hC0);
    wr(4'hB, 8'h40);
    wr(4'h4, 8'h03);
    wr(4'h5, 8'h00);
    rd_chk("R5 t1 loaded", 4'h4, 8'h03);
    ticks(3);
    rd_chk("R6 t1 at zero", 4'h4, 8'h00);
    check("R6 no flag at zero", {7'b0, irq}, 8'h00);
    ticks(1);
    check("R6 flag on wrap", {7'b0, irq}, 8'h01);
    rd_chk("R4 flag read t1", 4'hD, 8'hC0);
    rd_chk("R6 wrapped hi", 4'h5, 8'hFF);
    check("R9 hi read keeps flag", {7'b0, irq}, 8'h01);
    ticks(1);
    rd_chk("R6 reload", 4'h4, 8'h03);
    check("R9 lo read clears t1", {7'b0, irq}, 8'h00);
    ticks(4);
    check("R7 continuous refire", {7'b0, irq}, 8'h01);
    wr(4'hD, 8'h40);
    check("R4 flag write clears", {7'b0, irq}, 8'h00);

    // R7: one-shot
    wr(4'hB, 8'h00);
    wr(4'h4, 8'h02);
    wr(4'h5, 8'h00);
    ticks(3);
    check("R7 one-shot fires", {7'b0, irq}, 8'h01);
    wr(4'hD, 8'h40);
    ticks(4);
    check("R7 one-shot silent", {7'b0, irq}, 8'h00);
    rd_chk("R6 one-shot keeps counting", 4'h4, 8'hFF);

    // R5: latch-high write clears flag, no reload
    wr(4'h5, 8'h00);
    ticks(3);
    check("R5 armed again", {7'b0, irq}, 8'h01);
    wr(4'h7, 8'h00);
    check("R5 latch hi clears flag", {7'b0, irq}, 8'h00);
    rd_chk("R5 latch hi no reload", 4'h4, 8'hFF);
    rd_chk("R5 latch hi readback", 4'h7, 8'h00);

    // R8: timer 2
    wr(4'hE, 8'hA0);
    wr(4'h8, 8'h02);
    wr(4'h9, 8'h00);
    rd_chk("R8 t2 loaded", 4'h8, 8'h02);
    ticks(2);
    check("R8 no flag at zero", {7'b0, irq}, 8'h00);
    ticks(1);
    check("R8 flag on wrap", {7'b0, irq}, 8'h01);
    rd_chk("R4 flag read t2", 4'hD, 8'hA0);
    rd_chk("R9 t2 hi read", 4'h9, 8'hFF);
    check("R9 t2 hi read keeps flag", {7'b0, irq}, 8'h01);
    rd_chk("R9 t2 lo read", 4'h8, 8'hFF);
    check("R9 t2 lo read clears", {7'b0, irq}, 8'h00);
    ticks(3);
    rd_chk("R8 no reload", 4'h8, 8'hFC);
    check("R8 single fire", {7'b0, irq}, 8'h00);
    wr(4'h9, 8'h00);
    ticks(3);
    check("R8 rearmed", {7'b0, irq}, 8'h01);
    wr(4'h9, 8'h00);
    check("R8 hi write clears", {7'b0, irq}, 8'h00);

    // R10: shift flag
    wr(4'hE, 8'h84);
    pulse_sr;
    check("R10 sr_set raises", {7'b0, irq}, 8'h01);
    rd_chk("R10 flag read", 4'hD, 8'h84);
    rd_chk("R10 shift data", 4'hA, 8'h96);
    check("R10 shift read clears", {7'b0, irq}, 8'h00);

    // R4: selective clear and enable gating
    pulse_sr;
    wr(4'h9, 8'h00);
    ticks(3);
    rd_chk("R4 two flags", 4'hD, 8'hA4);
    wr(4'hD, 8'h04);
    rd_chk("R4 clear only sr", 4'hD, 8'hA0);
    wr(4'hD, 8'h20);
    rd_chk("R4 all clear", 4'hD, 8'h00);
    pulse_sr;
    wr(4'hE, 8'h04);
    check("R4 disabled no irq", {7'b0, irq}, 8'h00);
    rd_chk("R4 pending not enabled", 4'hD, 8'h04);

    // R2: port-B write strobe
    wr(4'h0, 8'h11);
    check("R2 strobe after pb write", {7'b0, pb_wr_stb}, 8'h01);
    @(negedge clk);
    check("R2 strobe one cycle", {7'b0, pb_wr_stb}, 8'h00);
    wr(4'h1, 8'h11);
    check("R2 no strobe on pa write", {7'b0, pb_wr_stb}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule